// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus whose SDA line is being held low by a slave that lost track of a transfer. Once started, it leaves SDA released (the master does not acknowledge), clocks SCL through a fixed number of slow low/high cycles so that the stuck slave can shift out the rest of its byte, and then closes the bus with a STOP condition. Both lines are open-drain: the block only ever pulls a line low or lets it float.

A recovery run can be started in two ways. Software can pulse a start input. A watchdog can also start it on its own when the bus-busy indication from the main controller stays high for a programmed number of idle cycles. The watchdog may start only a limited number of runs while the bus stays busy, so that a bus that cannot be freed is not clocked forever. The length of each phase is set by a clock-ticks-per-microsecond parameter times a phase length in microseconds (about 20 µs by default).

Top module: `i2c_bus_unjam`

## Requirements
- R1: While reset is held and after it is released, sclDriveLow, sdaDriveLow, busy and done are all 0 until a recovery run starts.
- R2: swStart sampled high at a clock edge while idle starts a run, and busy reads 1 in the cycle that follows that edge.
- R3: A run first produces PULSE_COUNT (9 by default) SCL pulses. Each pulse pulls SCL low for H = TICKS_PER_US*HALF_PERIOD_US cycles and then releases it for H cycles.
- R4: sdaDriveLow stays 0 through every SCL pulse, so the master does not acknowledge.
- R5: After the last pulse, SCL is pulled low with SDA low for H cycles. SCL is then released with SDA still low for H cycles, and after that SDA is released. This forms a STOP condition.
- R6: Without clock stretching, busy stays high for exactly (2*PULSE_COUNT+2)*H cycles. done is 1 for exactly one cycle, the first cycle after busy falls, and never while busy is 1.
- R7: A phase in which SCL is released (pulse high phase or STOP hold) counts only cycles in which sclIn reads 1. Each cycle that a slave holds sclIn low lengthens that phase and busy by one cycle.
- R8: swStart while busy is ignored: the run in progress keeps its timing and no second run follows it.
- R9: With busBusy held high, a run starts by itself WDOG_CYCLES cycles after busBusy rose, or WDOG_CYCLES cycles after the previous run ended.
- R10: While busBusy stays high, the watchdog starts at most MAX_TRIES (2 by default) runs. A cycle with busBusy low rearms it.
- R11: swStart is not limited by the watchdog try count and starts a run even when the watchdog has used up its tries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swStart | input | 1 | Software request for a recovery run |
| busBusy | input | 1 | Bus-busy indication from the main controller; feeds the watchdog |
| sclIn | input | 1 | Sampled level of the SCL line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A recovery run is in progress |
| done | output | 1 | One-cycle pulse when a run has finished |

## Verification
Software-started runs are tried with no stretching and with random stretches of random length placed on a randomly chosen released-SCL phase. The list of line-drive segments seen in each case is compared against the ideal 20-segment pattern. This separates a wrong pulse count, a wrong phase length, stretch cycles that are counted or dropped wrongly, and a STOP whose edges come in the wrong order. A start pulse in the middle of a run shows whether the timing is disturbed or a second run follows. Watchdog patterns hold busBusy high across two runs and then a long quiet window, then start a run by software with the tries used up, and then drop busBusy for a single cycle. These tell apart the start latency, the try limit, rearming by an idle bus, and the software start being independent of the watchdog.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE_LOW,
    ST_PULSE_HIGH,
    ST_STOP_LOW,
    ST_STOP_HOLD
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic timerClear;
    logic timerRun;
    logic pulseClear;
    logic pulseStep;
    logic seqIdle;
  } seqStrobes_t;

  // datapath -> control flags
  typedef struct packed {
    logic timerAtEnd;
    logic lastPulse;
    logic wdFire;
  } seqFlags_t;

endpackage

// File: rtl/unjam_datapath.sv
module unjam_datapath
  import i2c_unjam_pkg::*;
#(
  parameter int HALF_CYCLES = 1000,
  parameter int PULSE_COUNT = 9,
  parameter int WDOG_CYCLES = 5000,
  parameter int MAX_TRIES   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busBusy,
  input  seqStrobes_t strobes,
  output seqFlags_t   flags
);
  localparam int TW = $clog2(HALF_CYCLES + 1);
  localparam int PW = $clog2(PULSE_COUNT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(HALF_CYCLES - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PULSE_COUNT - 1);

  logic [TW-1:0] timerCnt;
  logic [PW-1:0] pulseIdx;
  logic wdFire;

  // phase timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerCnt <= '0;
    else if (strobes.timerClear) timerCnt <= '0;
    else if (strobes.timerRun) timerCnt <= timerCnt + 1'b1;
  end

  // pulse counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseIdx <= '0;
    else if (strobes.pulseClear) pulseIdx <= '0;
    else if (strobes.pulseStep) pulseIdx <= pulseIdx + 1'b1;
  end

  generate
    if (MAX_TRIES > 0) begin : g_wdog
      localparam int WW = $clog2(WDOG_CYCLES + 1);
      localparam int RW = $clog2(MAX_TRIES + 1);
      localparam logic [WW-1:0] W_LAST = WW'(WDOG_CYCLES - 1);
      localparam logic [RW-1:0] R_MAX  = RW'(MAX_TRIES);
      logic [WW-1:0] wdCnt;
      logic [RW-1:0] tries;

      assign wdFire = strobes.seqIdle && busBusy && (wdCnt == W_LAST) && (tries < R_MAX);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wdCnt <= '0;
          tries <= '0;
        end else if (!busBusy) begin
          wdCnt <= '0;
          tries <= '0;
        end else if (!strobes.seqIdle) begin
          wdCnt <= '0;
        end else if (wdFire) begin
          wdCnt <= '0;
          tries <= tries + 1'b1;
        end else if (wdCnt != W_LAST) begin
          wdCnt <= wdCnt + 1'b1;
        end
      end
    end else begin : g_nowdog
      assign wdFire = 1'b0;
    end
  endgenerate

  assign flags.timerAtEnd = (timerCnt == T_LAST);
  assign flags.lastPulse  = (pulseIdx == P_LAST);
  assign flags.wdFire     = wdFire;

endmodule

// File: rtl/unjam_control.sv
module unjam_control
  import i2c_unjam_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swStart,
  input  logic        sclIn,
  input  seqFlags_t   flags,
  output seqStrobes_t strobes,
  output logic        sclDriveLow,
  output logic        sdaDriveLow,
  output logic        busy,
  output logic        done
);
  seqState_t state, nextState;
  logic finishing;
  logic phaseEnd;

  always_comb begin
    strobes         = '0;
    strobes.seqIdle = (state == ST_IDLE);
    nextState       = state;
    finishing       = 1'b0;
    phaseEnd        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobes.timerClear = 1'b1;
        strobes.pulseClear = 1'b1;
        if (swStart || flags.wdFire) nextState = ST_PULSE_LOW;
      end
      ST_PULSE_LOW: begin
        strobes.timerRun = 1'b1;
        phaseEnd = flags.timerAtEnd;
        if (phaseEnd) nextState = ST_PULSE_HIGH;
      end
      ST_PULSE_HIGH: begin
        strobes.timerRun = sclIn;
        phaseEnd = sclIn && flags.timerAtEnd;
        if (phaseEnd) begin
          if (flags.lastPulse) nextState = ST_STOP_LOW;
          else begin
            strobes.pulseStep = 1'b1;
            nextState = ST_PULSE_LOW;
          end
        end
      end
      ST_STOP_LOW: begin
        strobes.timerRun = 1'b1;
        phaseEnd = flags.timerAtEnd;
        if (phaseEnd) nextState = ST_STOP_HOLD;
      end
      ST_STOP_HOLD: begin
        strobes.timerRun = sclIn;
        phaseEnd = sclIn && flags.timerAtEnd;
        if (phaseEnd) begin
          finishing = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (phaseEnd) strobes.timerClear = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finishing;
    end
  end

  assign sclDriveLow = (state == ST_PULSE_LOW) || (state == ST_STOP_LOW);
  assign sdaDriveLow = (state == ST_STOP_LOW) || (state == ST_STOP_HOLD);
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
  import i2c_unjam_pkg::*;
#(
  parameter int TICKS_PER_US   = 50,
  parameter int HALF_PERIOD_US = 20,
  parameter int PULSE_COUNT    = 9,
  parameter int WDOG_CYCLES    = 5000,
  parameter int MAX_TRIES      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic swStart,
  input  logic busBusy,
  input  logic sclIn,
  output logic sclDriveLow,
  output logic sdaDriveLow,
  output logic busy,
  output logic done
);
  localparam int HALF_CYCLES = TICKS_PER_US * HALF_PERIOD_US;

  seqStrobes_t strobes;
  seqFlags_t   flags;

  unjam_control u_ctrl (
    .clk(clk), .rstN(rstN), .swStart(swStart), .sclIn(sclIn),
    .flags(flags), .strobes(strobes),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done)
  );

  unjam_datapath #(
    .HALF_CYCLES(HALF_CYCLES), .PULSE_COUNT(PULSE_COUNT),
    .WDOG_CYCLES(WDOG_CYCLES), .MAX_TRIES(MAX_TRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busBusy(busBusy),
    .strobes(strobes), .flags(flags)
  );

endmodule

// File: rtl/i2c_bus_unjam_checks.sv
module i2c_bus_unjam_checks (
  input logic clk,
  input logic rstN,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic busy,
  input logic done
);
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  assert_low_keeps_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |=> busy);

  assert_sda_falls_under_low_scl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> sclDriveLow);

  assert_sda_release_ends_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> (!sclDriveLow && !busy && done));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

bind i2c_bus_unjam i2c_bus_unjam_checks u_checks (
  .clk(clk), .rstN(rstN), .sclDriveLow(sclDriveLow),
  .sdaDriveLow(sdaDriveLow), .busy(busy), .done(done)
);

// File: tb/i2c_bus_unjam_test.sv
module i2c_bus_unjam_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPU = 2;
  localparam int HPU = 3;
  localparam int H   = TPU * HPU;
  localparam int PC  = 9;
  localparam int NSEG = 2 * PC + 2;
  localparam int WD  = 40;
  localparam int MT  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swStart = 1'b0;
  logic busBusy = 1'b0;
  logic stretch = 1'b0;
  logic sclIn, sclDriveLow, sdaDriveLow, busy, done;

  int checks = 0;
  int failures = 0;

  // monitor state
  int segN = 0;
  int busyLen = 0;
  int doneCnt = 0;
  int overlap = 0;
  int stretchSeg = -1;
  int stretchLeft = 0;
  logic [1:0] lastKind = 2'b00;
  logic [1:0] segKind [32];
  int segLen [32];

  assign sclIn = !(sclDriveLow || stretch);

  i2c_bus_unjam #(
    .TICKS_PER_US(TPU), .HALF_PERIOD_US(HPU), .PULSE_COUNT(PC),
    .WDOG_CYCLES(WD), .MAX_TRIES(MT)
  ) uut (
    .clk(clk), .rstN(rstN), .swStart(swStart), .busBusy(busBusy),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (busy) begin
      if (segN == 0 || {sclDriveLow, sdaDriveLow} != lastKind) begin
        if (segN < 32) begin
          segKind[segN] = {sclDriveLow, sdaDriveLow};
          segLen[segN] = 1;
        end
        segN = segN + 1;
        lastKind = {sclDriveLow, sdaDriveLow};
      end else if (segN <= 32) begin
        segLen[segN-1] = segLen[segN-1] + 1;
      end
      busyLen = busyLen + 1;
    end
    if (done) doneCnt = doneCnt + 1;
    if (done && busy) overlap = overlap + 1;
    if (busy && segN > 0 && (segN - 1) == stretchSeg && stretchLeft > 0) begin
      stretch = 1'b1;
      stretchLeft = stretchLeft - 1;
    end else begin
      stretch = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // expected drive kind {scl,sda} of segment i
  function automatic logic [1:0] expKind(input int i);
    if (i < 2 * PC) return (i % 2 == 0) ? 2'b10 : 2'b00;
    return (i == 2 * PC) ? 2'b11 : 2'b01;
  endfunction

  function automatic int expLen(input int i, input int sSeg, input int s);
    return H + ((i == sSeg) ? s : 0);
  endfunction

  task automatic clearMon(input int sSeg, input int s);
    segN = 0; busyLen = 0; doneCnt = 0; overlap = 0;
    stretchSeg = sSeg; stretchLeft = s;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkRun(input int sSeg, input int s, input string tag);
    int badPulse = 0;
    int badStop = 0;
    int badLen = 0;
    int firstBadLen = 0;
    int lim;
    lim = (segN < NSEG) ? segN : NSEG;
    for (int i = 0; i < lim; i++) begin
      if (segKind[i] != expKind(i)) begin
        if (i < 2 * PC) badPulse++;
        else badStop++;
      end
      if (segLen[i] != expLen(i, sSeg, s)) begin
        if (badLen == 0) firstBadLen = segLen[i];
        badLen++;
      end
    end
    check(segN == NSEG, {tag, " R3 segment count"}, segN, NSEG);
    check(badPulse == 0, {tag, " R3 R4 pulse phases keep SDA released"}, badPulse, 0);
    check(badStop == 0, {tag, " R5 STOP order"}, badStop, 0);
    check(badLen == 0, {tag, " R3 R7 phase lengths"}, firstBadLen, H);
    check(busyLen == NSEG * H + s, {tag, " R6 R7 busy length"}, busyLen, NSEG * H + s);
    check(doneCnt == 1 && overlap == 0, {tag, " R6 single done after busy"}, doneCnt, 1);
  endtask

  task automatic swRun(input int sSeg, input int s, input bit midPoke, input string tag);
    clearMon(sSeg, s);
    @(negedge clk) swStart = 1'b1;
    @(negedge clk) swStart = 1'b0;
    check(busy == 1'b1, {tag, " R2 busy after start"}, int'(busy), 1);
    if (midPoke) begin
      repeat (3 * H) @(negedge clk);
      swStart = 1'b1;
      @(negedge clk) swStart = 1'b0;
    end
    waitIdle();
    checkRun(sSeg, s, tag);
    if (midPoke) check(busy == 1'b0, {tag, " R8 no restart after poke"}, int'(busy), 0);
  endtask

  task automatic waitStart(output int n);
    n = 0;
    while (!busy && n < 10 * WD) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    bit sawStart;
    void'($urandom(32'd2417));
    repeat (2) @(negedge clk);
    check({sclDriveLow, sdaDriveLow, busy, done} == 4'b0, "R1 in reset", {sclDriveLow, sdaDriveLow, busy, done}, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({sclDriveLow, sdaDriveLow, busy, done} == 4'b0, "R1 after reset", {sclDriveLow, sdaDriveLow, busy, done}, 0);

    // directed
    swRun(-1, 0, 1'b0, "plain");
    swRun(-1, 0, 1'b1, "poke");
    swRun(NSEG - 1, 3, 1'b0, "stop-stretch");
    swRun(1, 1, 1'b0, "first-high-stretch");

    // random
    for (int k = 0; k < 12; k++) begin
      int seg;
      int s;
      seg = 1 + 2 * int'($urandom_range(0, PC));
      s = int'($urandom_range(0, 6));
      swRun(seg, s, 1'b0, "random");
    end

    // watchdog
    clearMon(-1, 0);
    @(negedge clk) busBusy = 1'b1;
    waitStart(n);
    check(n == WD, "R9 first watchdog start latency", n, WD);
    waitIdle();
    checkRun(-1, 0, "wd1");
    clearMon(-1, 0);
    n = 4;
    while (!busy && n < 10 * WD) begin
      @(negedge clk);
      n++;
    end
    check(n == WD, "R9 second watchdog start latency", n, WD);
    waitIdle();
    sawStart = 1'b0;
    for (int i = 0; i < 3 * WD; i++) begin
      @(negedge clk);
      if (busy) sawStart = 1'b1;
    end
    check(!sawStart, "R10 try limit reached", int'(sawStart), 0);

    swRun(-1, 0, 1'b0, "R11 sw after exhaustion");
    sawStart = 1'b0;
    for (int i = 0; i < 2 * WD; i++) begin
      @(negedge clk);
      if (busy) sawStart = 1'b1;
    end
    check(!sawStart, "R10 still exhausted after sw run", int'(sawStart), 0);

    busBusy = 1'b0;
    @(negedge clk) busBusy = 1'b1;
    clearMon(-1, 0);
    waitStart(n);
    check(n == WD, "R10 rearm after idle bus", n, WD);
    busBusy = 1'b0;
    waitIdle();
    checkRun(-1, 0, "wd-rearm");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule